// File: doc/BRIEF.md
# IPC Acknowledge Interrupt Controller

This block gathers acknowledge events from up to 32 mailbox vectors and turns them into one interrupt line for the local core. Each event pulse latches into a pending bit. Software can read the pending bits unfiltered, or filtered by an enable mask. It retires a bit by writing a one to it in a clear register. The mask can be written as a whole word, or changed one bit at a time through two write-one ports: one sets mask bits, the other removes them.

The same register window also holds an outgoing doorbell register. Writing a word there raises a one-cycle pulse on each peer interrupt line whose bit was one. Software maps vectors to channels; the block has no notion of channels. Access is by a plain 32-bit register bus. Writes take effect at the clock edge. Read data is valid in the same cycle as the read strobe.

Top module: `ipc_ack_intc`

## Requirements
- R1: After reset, pending bits and mask bits are all zero, `irq_o` is low and `peer_irq_o` is zero.
- R2: A one on `ack_evt_i[n]` sets pending bit n at the next clock edge. The pending word reads back at offset 0x400 whatever the mask holds, and several bits may be pending at once.
- R3: A write to offset 0x404 replaces the whole mask (1 = vector enabled, 0 = masked). A read of 0x404 returns the mask.
- R4: A write to offset 0x500 sets each mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R5: A write to offset 0x504 clears each mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R6: A read of offset 0x408 returns the pending word ANDed with the mask.
- R7: `irq_o` is high exactly when at least one pending bit is also enabled.
- R8: A write to offset 0x40C clears each pending bit whose write-data bit is one and leaves the others alone. An all-ones write clears every pending bit.
- R9: If an event and a clear hit the same bit in the same cycle, the bit stays pending.
- R10: A write of word W to offset 0x420 makes `peer_irq_o` equal W for exactly the one cycle after the write. `peer_irq_o` is zero at every other time.
- R11: Reads of the write-only offsets 0x40C, 0x500, 0x504 and 0x420, and of any unmapped offset, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of `bus_rd_i` |
| ack_evt_i | input | 32 | Per-vector acknowledge event pulses |
| irq_o | output | 1 | Combined interrupt to the local core |
| peer_irq_o | output | 32 | One-cycle doorbell pulses to the peer core |

## Verification
An incoming acknowledge event and a software clear write can land on the same vector bit in the same clock. The bench provokes this by pulsing one event bit while it writes a clear word that covers that bit and several bits that are already pending, both in one cycle. It judges the result by reading the pending word afterwards. The collided bit must still be set, the other covered bits must be gone, and with that vector enabled `irq_o` must stay high.

// File: rtl/ipc_intc_pkg.sv
package ipc_intc_pkg;

    localparam int OFF_PEND   = 'h400;
    localparam int OFF_MASK   = 'h404;
    localparam int OFF_STAT   = 'h408;
    localparam int OFF_CLR    = 'h40C;
    localparam int OFF_DOORB  = 'h420;
    localparam int OFF_EN     = 'h500;
    localparam int OFF_DIS    = 'h504;

    typedef struct packed {
        logic pend_rd;
        logic mask_rd;
        logic stat_rd;
        logic mask_wr;
        logic clr_wr;
        logic en_wr;
        logic dis_wr;
        logic db_wr;
    } strobe_t;

endpackage

// File: rtl/ipc_intc_regdec.sv
module ipc_intc_regdec
    import ipc_intc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output strobe_t           stb_o
);

    always_comb begin
        stb_o         = '0;
        stb_o.pend_rd = rd_i && (addr_i == ADDR_W'(OFF_PEND));
        stb_o.mask_rd = rd_i && (addr_i == ADDR_W'(OFF_MASK));
        stb_o.stat_rd = rd_i && (addr_i == ADDR_W'(OFF_STAT));
        stb_o.mask_wr = wr_i && (addr_i == ADDR_W'(OFF_MASK));
        stb_o.clr_wr  = wr_i && (addr_i == ADDR_W'(OFF_CLR));
        stb_o.en_wr   = wr_i && (addr_i == ADDR_W'(OFF_EN));
        stb_o.dis_wr  = wr_i && (addr_i == ADDR_W'(OFF_DIS));
        stb_o.db_wr   = wr_i && (addr_i == ADDR_W'(OFF_DOORB));
    end

endmodule

// File: rtl/ipc_intc_vec_bank.sv
module ipc_intc_vec_bank
    import ipc_intc_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  strobe_t            stb_i,
    input  logic [NUM_VEC-1:0] wdata_i,
    input  logic [NUM_VEC-1:0] evt_i,
    output logic [NUM_VEC-1:0] pend_o,
    output logic [NUM_VEC-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_VEC-1:0] pend_nx;

    // Per-vector pending bit: a new event outranks a clear on the same bit.
    for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
        assign pend_nx[gi] = evt_i[gi] |
                             (bank_q.pend[gi] & ~(stb_i.clr_wr & wdata_i[gi]));
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = pend_nx;
        if (stb_i.mask_wr) begin
            bank_d.mask = wdata_i;
        end else if (stb_i.en_wr) begin
            bank_d.mask = bank_q.mask | wdata_i;
        end else if (stb_i.dis_wr) begin
            bank_d.mask = bank_q.mask & ~wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend_o = bank_q.pend;
    assign mask_o = bank_q.mask;

    AST_EVT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((bank_q.pend & $past(evt_i)) == $past(evt_i))); // R9

    AST_CLR_REMOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i.clr_wr |=> ((bank_q.pend & $past(wdata_i & ~evt_i)) == '0)); // R8

    AST_EN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i.en_wr |=> ((bank_q.mask & $past(wdata_i)) == $past(wdata_i))); // R4

    AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i.dis_wr |=> ((bank_q.mask & $past(wdata_i)) == '0)); // R5

    AST_DIS_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i.dis_wr |=> ((bank_q.mask & ~$past(wdata_i)) == ($past(bank_q.mask) & ~$past(wdata_i)))); // R5

endmodule

// File: rtl/ipc_intc_doorbell.sv
module ipc_intc_doorbell #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               db_wr_i,
    input  logic [NUM_VEC-1:0] wdata_i,
    output logic [NUM_VEC-1:0] peer_o
);

    typedef struct packed {
        logic [NUM_VEC-1:0] pulse;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d.pulse = db_wr_i ? wdata_i : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            db_q <= '0;
        end else begin
            db_q <= db_d;
        end
    end

    assign peer_o = db_q.pulse;

    AST_DB_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !db_wr_i |=> (peer_o == '0)); // R10

    AST_DB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        db_wr_i |=> (peer_o == $past(wdata_i))); // R10

endmodule

// File: rtl/ipc_ack_intc.sv
module ipc_ack_intc
    import ipc_intc_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [NUM_VEC-1:0] ack_evt_i,
    output logic               irq_o,
    output logic [NUM_VEC-1:0] peer_irq_o
);

    strobe_t            stb;
    logic [NUM_VEC-1:0] wvec;
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] mask;
    logic [NUM_VEC-1:0] masked;

    assign wvec = bus_wdata_i[NUM_VEC-1:0];

    ipc_intc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_i   (bus_wr_i),
        .rd_i   (bus_rd_i),
        .addr_i (bus_addr_i),
        .stb_o  (stb)
    );

    ipc_intc_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stb_i   (stb),
        .wdata_i (wvec),
        .evt_i   (ack_evt_i),
        .pend_o  (pend),
        .mask_o  (mask)
    );

    ipc_intc_doorbell #(.NUM_VEC(NUM_VEC)) u_db (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .db_wr_i (stb.db_wr),
        .wdata_i (wvec),
        .peer_o  (peer_irq_o)
    );

    assign masked = pend & mask;
    assign irq_o  = |masked;

    always_comb begin
        bus_rdata_o = '0;
        if (stb.pend_rd) begin
            bus_rdata_o[NUM_VEC-1:0] = pend;
        end else if (stb.mask_rd) begin
            bus_rdata_o[NUM_VEC-1:0] = mask;
        end else if (stb.stat_rd) begin
            bus_rdata_o[NUM_VEC-1:0] = masked;
        end
    end

    AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (bus_addr_i == ADDR_W'(OFF_CLR) || bus_addr_i == ADDR_W'(OFF_DOORB) ||
                      bus_addr_i == ADDR_W'(OFF_EN)  || bus_addr_i == ADDR_W'(OFF_DIS)))
        |-> (bus_rdata_o == '0)); // R11

    AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |-> (bus_rdata_o == '0)); // R11

endmodule

// File: tb/ipc_ack_intc_tb_top.sv
module ipc_ack_intc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] evt = '0;
    logic        irq;
    logic [31:0] peer;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ipc_ack_intc dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .ack_evt_i   (evt),
        .irq_o       (irq),
        .peer_irq_o  (peer)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse_evt(input logic [31:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 peer", peer, 32'h0);
        bus_read('h400, r); check("R1 pend", r, 32'h0);
        bus_read('h404, r); check("R1 mask", r, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] r;
        pulse_evt(32'h8000_0011);
        bus_read('h400, r); check("R2 pend multi", r, 32'h8000_0011);
        check("R7 masked no irq", {31'b0, irq}, 32'h0);
        bus_read('h408, r); check("R6 stat masked", r, 32'h0);
    endtask

    task automatic t_mask_word();
        logic [31:0] r;
        bus_write('h404, 32'h0000_0010);
        bus_read('h404, r); check("R3 mask word", r, 32'h0000_0010);
        bus_read('h408, r); check("R6 stat", r, 32'h0000_0010);
        check("R7 irq on", {31'b0, irq}, 32'h1);
        bus_write('h404, 32'h0);
        bus_read('h404, r); check("R3 mask all off", r, 32'h0);
        check("R7 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] r;
        bus_write('h404, 32'h0000_0100);
        bus_write('h500, 32'h8000_0001);
        bus_read('h404, r); check("R4 enable or", r, 32'h8000_0101);
        bus_write('h500, 32'h0);
        bus_read('h404, r); check("R4 zero no effect", r, 32'h8000_0101);
        bus_read('h408, r); check("R6 stat enabled", r, 32'h8000_0001);
    endtask

    task automatic t_disable();
        logic [31:0] r;
        bus_write('h504, 32'h8000_0100);
        bus_read('h404, r); check("R5 disable", r, 32'h0000_0001);
        bus_write('h504, 32'h0);
        bus_read('h404, r); check("R5 zero no effect", r, 32'h0000_0001);
        check("R7 irq bit0", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] r;
        bus_write('h40C, 32'h0000_0001);
        bus_read('h400, r); check("R8 clear one", r, 32'h8000_0010);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);
        pulse_evt(32'h0F0F_0000);
        bus_write('h40C, 32'hFFFF_FFFF);
        bus_read('h400, r); check("R8 clear all", r, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] r;
        pulse_evt(32'h0000_00F0);
        bus_write('h404, 32'h0000_0020);
        @(negedge clk);
        wr = 1'b1; addr = 'h40C; wdata = 32'h0000_00F0; evt = 32'h0000_0020;
        @(negedge clk);
        wr = 1'b0; wdata = '0; evt = '0;
        bus_read('h400, r); check("R9 event wins", r, 32'h0000_0020);
        check("R9 irq held", {31'b0, irq}, 32'h1);
        bus_write('h40C, 32'hFFFF_FFFF);
    endtask

    task automatic t_doorbell();
        logic [31:0] r;
        @(negedge clk);
        wr = 1'b1; addr = 'h420; wdata = 32'hA000_0005;
        check("R10 before edge", peer, 32'h0);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        check("R10 pulse", peer, 32'hA000_0005);
        @(negedge clk);
        check("R10 self clear", peer, 32'h0);
        bus_read('h420, r); check("R10 read zero", r, 32'h0);
    endtask

    task automatic t_write_only();
        logic [31:0] r;
        bus_write('h404, 32'hFFFF_FFFF);
        pulse_evt(32'h0000_0003);
        bus_read('h40C, r); check("R11 clr reads 0", r, 32'h0);
        bus_read('h500, r); check("R11 en reads 0", r, 32'h0);
        bus_read('h504, r); check("R11 dis reads 0", r, 32'h0);
        bus_read('h7FC, r); check("R11 unmapped 0", r, 32'h0);
        bus_read('h400, r); check("R11 pend intact", r, 32'h0000_0003);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_mask_word();
        t_enable();
        t_disable();
        t_clear();
        t_collision();
        t_doorbell();
        t_write_only();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog got timeout exp completion");
        finish_run();
    end

endmodule